// File: doc/BRIEF.md
# Low-Power Wakeup Qualification Controller

This block decides when a processor core may drop into a low-power state and when it must come back out. It holds one 8-bit control register with two fields. The top bit arms low-power entry. The low three bits set the minimum interrupt priority that counts as a wake source. Bits 6 to 3 are reserved.

The core raises an entry request, for example while executing a stop instruction. The block then goes to sleep, unless entry is disarmed or an interrupt that already qualifies is pending. While asleep it watches the pending interrupt level coming from the interrupt controller, where 0 means nothing is pending. When that level reaches the programmed minimum, it emits a one-cycle wake pulse and returns to run state. The mode-select value from a separate register is captured when the block goes to sleep and is presented on an output for the clock-gating logic. That logic, and the interrupt controller, sit outside this block.

All pins are plain control and status signals. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure to describe.

Top module: `lp_wake_ctrl`

## Requirements
- R1: After an asynchronous active-low reset, the control register reads 0x00, `lp_active` is 0 and `wake_pulse` is 0.
- R2: A write updates bit 7 (entry arm) and bits 2..0 (wake threshold) from `cfg_wr_data`. Bits 6..3 ignore written data and always read as 0. The read data reflects a write from the clock edge that accepts it.
- R3: With bit 7 cleared, an asserted `lp_enter_req` is ignored and `lp_active` stays 0.
- R4: With bit 7 set and no qualifying interrupt, `lp_enter_req` sampled at a clock edge sets `lp_active` from that edge.
- R5: Threshold code 000 wakes on any pending level from 1 to 7. Level 0 never wakes.
- R6: Threshold codes 001 to 101 wake only on a level at least the code plus one. For example, code 011 needs a level of 4 or more.
- R7: Threshold codes 110 and 111 both wake only on level 7.
- R8: When a qualifying level is sampled while asleep, `lp_active` clears at that edge and `wake_pulse` is 1 for exactly the following cycle. A non-qualifying level leaves `lp_active` set and `wake_pulse` at 0.
- R9: An entry request sampled in the same cycle as a level that already qualifies does not enter low power.
- R10: A threshold written while asleep is used from the comparison at the edge after the write edge. The write edge itself uses the old threshold.
- R11: `lp_mode` captures `mode_sel` at the edge that enters low power and holds that value while asleep, even if `mode_sel` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | REG_W (8) | Control register write data |
| cfg_rd_data | output | REG_W (8) | Control register contents, reserved bits zero |
| lp_enter_req | input | 1 | Request to enter low power |
| irq_level | input | LVL_W (3) | Pending interrupt level, 0 = none |
| mode_sel | input | MODE_W (2) | Low-power mode value from the mode-select register |
| lp_active | output | 1 | Block is in the low-power state |
| lp_mode | output | MODE_W (2) | Mode captured at entry |
| wake_pulse | output | 1 | One-cycle pulse on leaving low power |

## Verification
The bench sweeps every threshold code against the levels on either side of its boundary. A design with an off-by-one comparator would wake one level too early or stay asleep at the exact minimum, and a design that treats code 110 as "level 6 and up" would wake on level 6. Directed tests aim at the race between an entry request and an interrupt that already qualifies: a wrong design would sleep and then wake a cycle later instead of never sleeping. They also check a threshold rewrite while asleep with the level held steady, where a design that compares against the incoming write data wakes one cycle early. Finally, they check reserved-bit writes, which must read back as zero, and a mode-select change while asleep, which must not reach `lp_mode`.

// File: rtl/lp_wake_pkg.sv
package lp_wake_pkg;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } lp_state_e;

endpackage

// File: rtl/lp_ctrl_reg.sv
module lp_ctrl_reg #(
  parameter int REG_W = 8,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             arm,
  output logic [LVL_W-1:0] thresh,
  output logic [REG_W-1:0] rd_data
);
  localparam int RSV_W = REG_W - 1 - LVL_W;

  logic             arm_q;
  logic [LVL_W-1:0] thr_q;

  // Only the arm bit and the threshold field are stored; reserved bits have no flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      thr_q <= '0;
    end else if (wr_en) begin
      arm_q <= wr_data[REG_W-1];
      thr_q <= wr_data[LVL_W-1:0];
    end
  end

  assign arm     = arm_q;
  assign thresh  = thr_q;
  assign rd_data = {arm_q, {RSV_W{1'b0}}, thr_q};
endmodule

// File: rtl/lp_wake_qual.sv
module lp_wake_qual #(
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] thresh,
  input  logic [LVL_W-1:0] irq_level,
  output logic             qualifies
);
  localparam logic [LVL_W-1:0] TOP_LVL = '1;
  localparam logic [LVL_W-1:0] ONE     = LVL_W'(1);

  logic [LVL_W-1:0] min_lvl;

  // Code 0 means any request; the two highest codes both saturate at the top level.
  always_comb begin
    if (thresh == '0)
      min_lvl = ONE;
    else if (thresh >= TOP_LVL - ONE)
      min_lvl = TOP_LVL;
    else
      min_lvl = thresh + ONE;
  end

  assign qualifies = (irq_level != '0) && (irq_level >= min_lvl);
endmodule

// File: rtl/lp_state_seq.sv
module lp_state_seq
  import lp_wake_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_req,
  input  logic              arm,
  input  logic              qualifies,
  input  logic [MODE_W-1:0] mode_in,
  output logic              lp_active,
  output logic              wake,
  output logic [MODE_W-1:0] mode_out
);
  lp_state_e         st_q;
  logic              wake_q;
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      wake_q <= 1'b0;
      mode_q <= '0;
    end else begin
      wake_q <= 1'b0;
      case (st_q)
        ST_RUN: begin
          if (enter_req && arm && !qualifies) begin
            st_q   <= ST_SLEEP;
            mode_q <= mode_in;
          end
        end
        ST_SLEEP: begin
          if (qualifies) begin
            st_q   <= ST_RUN;
            wake_q <= 1'b1;
          end
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign lp_active = (st_q == ST_SLEEP);
  assign wake      = wake_q;
  assign mode_out  = mode_q;
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl #(
  parameter int REG_W  = 8,
  parameter int LVL_W  = 3,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [REG_W-1:0]  cfg_wr_data,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic              lp_enter_req,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [MODE_W-1:0] mode_sel,
  output logic              lp_active,
  output logic [MODE_W-1:0] lp_mode,
  output logic              wake_pulse
);
  logic             arm;
  logic [LVL_W-1:0] thresh;
  logic             qualifies;

  lp_ctrl_reg #(.REG_W(REG_W), .LVL_W(LVL_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .arm     (arm),
    .thresh  (thresh),
    .rd_data (cfg_rd_data)
  );

  lp_wake_qual #(.LVL_W(LVL_W)) u_qual (
    .thresh    (thresh),
    .irq_level (irq_level),
    .qualifies (qualifies)
  );

  lp_state_seq #(.MODE_W(MODE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter_req (lp_enter_req),
    .arm       (arm),
    .qualifies (qualifies),
    .mode_in   (mode_sel),
    .lp_active (lp_active),
    .wake      (wake_pulse),
    .mode_out  (lp_mode)
  );
endmodule

// File: rtl/lp_wake_ctrl_chk.sv
module lp_wake_ctrl_chk #(
  parameter int REG_W  = 8,
  parameter int LVL_W  = 3,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_W-1:0]  cfg_rd_data,
  input logic              lp_enter_req,
  input logic [LVL_W-1:0]  irq_level,
  input logic              lp_active,
  input logic [MODE_W-1:0] lp_mode,
  input logic              wake_pulse
);
  // R8: the wake pulse never lasts two cycles
  a_r8_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  // R8: a wake pulse follows a cycle spent asleep and comes with run state
  a_r8_wake_leaves_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_pulse) |-> (!lp_active && $past(lp_active)));

  // R3/R4: sleep begins only after a request seen while armed
  a_r3_entry_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_active) |-> ($past(lp_enter_req) && $past(cfg_rd_data[REG_W-1])));

  // R8: a zero level can never end sleep
  a_r5_zero_level_keeps_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_active && irq_level == '0) |=> lp_active);

  // R2: reserved bits read as zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[REG_W-2:LVL_W] == '0);

  // R11: captured mode holds while asleep
  a_r11_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_active && $past(lp_active)) |-> $stable(lp_mode));
endmodule

bind lp_wake_ctrl lp_wake_ctrl_chk #(.REG_W(REG_W), .LVL_W(LVL_W), .MODE_W(MODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_rd_data  (cfg_rd_data),
  .lp_enter_req (lp_enter_req),
  .irq_level    (irq_level),
  .lp_active    (lp_active),
  .lp_mode      (lp_mode),
  .wake_pulse   (wake_pulse)
);

// File: tb/lp_wake_ctrl_test.sv
`timescale 1ns/1ps
module lp_wake_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = 8'h00;
  logic [7:0] cfg_rd_data;
  logic       lp_enter_req = 1'b0;
  logic [2:0] irq_level = 3'd0;
  logic [1:0] mode_sel = 2'd0;
  logic       lp_active;
  logic [1:0] lp_mode;
  logic       wake_pulse;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lp_wake_ctrl uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_data  (cfg_wr_data),
    .cfg_rd_data  (cfg_rd_data),
    .lp_enter_req (lp_enter_req),
    .irq_level    (irq_level),
    .mode_sel     (mode_sel),
    .lp_active    (lp_active),
    .lp_mode      (lp_mode),
    .wake_pulse   (wake_pulse)
  );

  // {threshold code, pending level, wake expected}
  localparam int NVEC = 17;
  localparam logic [6:0] VEC [NVEC] = '{
    {3'd0, 3'd1, 1'b1}, {3'd0, 3'd7, 1'b1}, {3'd0, 3'd0, 1'b0},
    {3'd1, 3'd1, 1'b0}, {3'd1, 3'd2, 1'b1}, {3'd2, 3'd2, 1'b0},
    {3'd2, 3'd3, 1'b1}, {3'd3, 3'd3, 1'b0}, {3'd3, 3'd4, 1'b1},
    {3'd4, 3'd4, 1'b0}, {3'd4, 3'd5, 1'b1}, {3'd5, 3'd5, 1'b0},
    {3'd5, 3'd6, 1'b1}, {3'd6, 3'd6, 1'b0}, {3'd6, 3'd7, 1'b1},
    {3'd7, 3'd6, 1'b0}, {3'd7, 3'd7, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_wr_en = 1'b1;
    cfg_wr_data = d;
    tick();
    cfg_wr_en = 1'b0;
  endtask

  task automatic enter();
    lp_enter_req = 1'b1;
    tick();
    lp_enter_req = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 rd_data", cfg_rd_data, 0);
    check("R1 lp_active", lp_active, 0);
    check("R1 wake_pulse", wake_pulse, 0);
    rst_n = 1'b1;
    tick();

    // R2 reserved bits dropped
    wr(8'hFF);
    check("R2 readback", cfg_rd_data, 8'h87);
    wr(8'h7A);
    check("R2 readback", cfg_rd_data, 8'h02);

    // R3 disarmed request ignored
    wr(8'h05);
    enter();
    check("R3 no entry", lp_active, 0);
    tick();
    check("R3 still run", lp_active, 0);

    // Table sweep: R5, R6, R7, R4, R8
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] code;
      logic [2:0] lvl;
      logic       exp;
      string      tag;
      code = VEC[i][6:4];
      lvl  = VEC[i][3:1];
      exp  = VEC[i][0];
      tag  = (code == 3'd0) ? "R5" : (code >= 3'd6) ? "R7" : "R6";
      wr({1'b1, 4'b0, code});
      enter();
      check("R4 entered", lp_active, 1);
      irq_level = lvl;
      tick();
      irq_level = 3'd0;
      check({tag, " wake"}, wake_pulse, exp);
      check({tag, " lp_active"}, lp_active, !exp);
      if (exp) begin
        tick();
        check("R8 pulse width", wake_pulse, 0);
      end else begin
        irq_level = 3'd7;
        tick();
        irq_level = 3'd0;
        check("R8 level7 wake", wake_pulse, 1);
        tick();
      end
    end

    // R9 entry blocked by an already qualifying level
    wr(8'h83);
    irq_level = 3'd4;
    enter();
    check("R9 no entry", lp_active, 0);
    check("R9 no wake", wake_pulse, 0);
    irq_level = 3'd3;
    enter();
    check("R9 below thr enters", lp_active, 1);
    irq_level = 3'd7;
    tick();
    irq_level = 3'd0;
    tick();

    // R10 threshold rewrite while asleep, level held
    wr(8'h87);
    enter();
    irq_level = 3'd5;
    tick();
    check("R10 asleep at old thr", lp_active, 1);
    wr(8'h83);
    check("R10 write edge old thr", lp_active, 1);
    check("R10 write edge no wake", wake_pulse, 0);
    tick();
    check("R10 new thr wakes", wake_pulse, 1);
    check("R10 run", lp_active, 0);
    irq_level = 3'd0;
    tick();

    // R11 mode capture
    mode_sel = 2'd2;
    enter();
    mode_sel = 2'd1;
    tick();
    check("R11 mode captured", lp_mode, 2);
    tick();
    check("R11 mode held", lp_mode, 2);
    irq_level = 3'd7;
    tick();
    irq_level = 3'd0;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule